// File: doc/BRIEF.md
# Eight-Bit General-Purpose I/O Port with Peripheral Override

This block controls a byte-wide group of chip pins. Software sets it up through four registers on a simple synchronous bus: an output latch, a direction mask, a pullup mask and a slew-limit mask. For each pin the block produces an output value, an output enable, a pullup request and a slew-limit request for the pad. It also samples the pin level, through a two-stage synchronizer, so that software can read it back.

A serial peripheral can take over any pin through a per-bit ownership mask. On a pin it owns, the peripheral's own value and drive enable replace the port's latch and direction bit. The pad controls still follow the port's pullup and slew masks. The pullup is only allowed on a pin that is not being driven, and slew limiting only takes effect on a pin that is.

All pad-side outputs and the read data are registered. A register write reaches the pins on the clock edge after the one that stores it.

Top module: `gpio_port_ctrl`

## Requirements
- R1: While reset is high and after it is released, all four registers read 0, and pin_oe, pin_pullup, pin_slew and pin_out are all 0. Every pin is therefore an undriven input with no pullup.
- R2: A write to offset 0 stores all bits of the output latch whatever the direction mask holds. On a pin the peripheral does not own, pin_out shows the latch bit, and the latch bit is only driven when the direction bit is 1.
- R3: A read of offset 0 returns the latch bit where the direction bit is 1, and the synchronized pin level where it is 0.
- R4: Offsets 1 (pullup mask), 2 (slew mask) and 3 (direction mask, 1 = output, 0 = input) read back exactly the value last written. For pullup and slew, 1 means enabled.
- R5: A write to any offset from 4 to 7 changes no register, and a read of those offsets returns 0.
- R6: On a pin the peripheral does not own, pin_pullup is 1 only when the pullup bit is 1 and the direction bit is 0.
- R7: pin_slew is 1 only when the slew bit is 1 and the pin is driven (pin_oe is 1). This holds whether or not the peripheral owns the pin.
- R8: When per_own is 1 for a bit, pin_oe and pin_out follow per_oe and per_out, and the direction bit has no effect on them.
- R9: On an owned pin that the peripheral does not drive, pin_pullup is 1 only when the pullup bit is 1 and the direction bit is 0.
- R10: A change on pin_in first shows in an offset-0 read three clock edges after it. After two edges the read still shows the old level.
- R11: A register write that changes pad controls reaches the pad outputs one edge after the edge that stores it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 3 | Register offset |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data for the offset given on the previous edge |
| pin_in | input | 8 | Pin levels from the pads |
| pin_out | output | 8 | Value to drive on each pin |
| pin_oe | output | 8 | Output driver enable per pin |
| pin_pullup | output | 8 | Pullup request per pin |
| pin_slew | output | 8 | Slew-limit request per pin |
| per_own | input | 8 | Peripheral takes over the pin when 1 |
| per_out | input | 8 | Peripheral output value |
| per_oe | input | 8 | Peripheral drive enable |

## Verification
The hardest case to reach from the ports is a peripheral-owned pin where the peripheral's drive enable disagrees with the port's direction bit. Only in that case can a wrong source for the pullup or the output enable be told apart from a correct one. The table sets the direction, ownership and peripheral-enable masks to three patterns that are shifted against each other, so that the eight bits of one byte cover all eight combinations at once. The pullup, slew and latch masks vary from row to row. Directed steps then time the synchronizer delay and the output register delay edge by edge.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  typedef enum logic [1:0] {
    OFS_LATCH = 2'd0,
    OFS_PULL  = 2'd1,
    OFS_SLEW  = 2'd2,
    OFS_DIR   = 2'd3
  } gpio_ofs_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);
  logic [STAGES-1:0][WIDTH-1:0] chain_q;

  always_ff @(posedge clk) begin
    if (rst) chain_q <= '0;
    else     chain_q <= {chain_q[STAGES-2:0], async_in};
  end

  assign sync_out = chain_q[STAGES-1];
endmodule

// File: rtl/gpio_regfile.sv
module gpio_regfile
  import gpio_pkg::*;
#(
  parameter int WIDTH  = 8,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [WIDTH-1:0]  bus_wdata,
  input  logic [WIDTH-1:0]  pin_sync,
  output logic [WIDTH-1:0]  latch_q,
  output logic [WIDTH-1:0]  dir_q,
  output logic [WIDTH-1:0]  pull_q,
  output logic [WIDTH-1:0]  slew_q,
  output logic [WIDTH-1:0]  bus_rdata
);
  localparam int OFS_W = 2;

  logic mapped;
  gpio_ofs_e ofs;
  logic [WIDTH-1:0] rd_mux;

  assign mapped = (bus_addr >> OFS_W) == '0;
  assign ofs    = gpio_ofs_e'(bus_addr[OFS_W-1:0]);

  always_ff @(posedge clk) begin
    if (rst) begin
      latch_q <= '0;
      dir_q   <= '0;
      pull_q  <= '0;
      slew_q  <= '0;
    end else if (bus_wr && mapped) begin
      unique case (ofs)
        OFS_LATCH: latch_q <= bus_wdata;
        OFS_PULL:  pull_q  <= bus_wdata;
        OFS_SLEW:  slew_q  <= bus_wdata;
        OFS_DIR:   dir_q   <= bus_wdata;
        default:   ;
      endcase
    end
  end

  always_comb begin
    rd_mux = '0;
    if (mapped) begin
      unique case (ofs)
        OFS_LATCH: rd_mux = (dir_q & latch_q) | (~dir_q & pin_sync);
        OFS_PULL:  rd_mux = pull_q;
        OFS_SLEW:  rd_mux = slew_q;
        OFS_DIR:   rd_mux = dir_q;
        default:   rd_mux = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else     bus_rdata <= rd_mux;
  end

  assert_unmapped_write_R5: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && !mapped) |=> ($stable(latch_q) && $stable(dir_q) && $stable(pull_q) && $stable(slew_q)));

  assert_unmapped_read_R5: assert property (@(posedge clk) disable iff (rst)
    !mapped |=> bus_rdata == '0);

  assert_dir_write_R4: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && mapped && ofs == OFS_DIR) |=> dir_q == $past(bus_wdata));

  assert_reset_regs_R1: assert property (@(posedge clk)
    rst |=> (latch_q == '0 && dir_q == '0 && pull_q == '0 && slew_q == '0));
endmodule

// File: rtl/gpio_pin_mux.sv
module gpio_pin_mux #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] latch_q,
  input  logic [WIDTH-1:0] dir_q,
  input  logic [WIDTH-1:0] pull_q,
  input  logic [WIDTH-1:0] slew_q,
  input  logic [WIDTH-1:0] per_own,
  input  logic [WIDTH-1:0] per_out,
  input  logic [WIDTH-1:0] per_oe,
  output logic [WIDTH-1:0] pin_out,
  output logic [WIDTH-1:0] pin_oe,
  output logic [WIDTH-1:0] pin_pullup,
  output logic [WIDTH-1:0] pin_slew
);
  for (genvar b = 0; b < WIDTH; b++) begin : g_pin
    logic drive;
    logic value;
    assign drive = per_own[b] ? per_oe[b]  : dir_q[b];
    assign value = per_own[b] ? per_out[b] : latch_q[b];

    always_ff @(posedge clk) begin
      if (rst) begin
        pin_out[b]    <= 1'b0;
        pin_oe[b]     <= 1'b0;
        pin_pullup[b] <= 1'b0;
        pin_slew[b]   <= 1'b0;
      end else begin
        pin_out[b]    <= value;
        pin_oe[b]     <= drive;
        pin_pullup[b] <= pull_q[b] & ~dir_q[b] & ~drive;
        pin_slew[b]   <= slew_q[b] & drive;
      end
    end
  end

  assert_pull_not_driven_R6: assert property (@(posedge clk) disable iff (rst)
    (pin_pullup & pin_oe) == '0);

  assert_slew_needs_drive_R7: assert property (@(posedge clk) disable iff (rst)
    (pin_slew & ~pin_oe) == '0);

  assert_owned_pull_dir_R9: assert property (@(posedge clk) disable iff (rst)
    (($past(per_own) & $past(dir_q)) & pin_pullup) == '0);

  assert_reset_pads_R1: assert property (@(posedge clk)
    rst |=> (pin_oe == '0 && pin_pullup == '0 && pin_slew == '0 && pin_out == '0));
endmodule

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl #(
  parameter int WIDTH       = 8,
  parameter int ADDR_W      = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [WIDTH-1:0]  bus_wdata,
  output logic [WIDTH-1:0]  bus_rdata,
  input  logic [WIDTH-1:0]  pin_in,
  output logic [WIDTH-1:0]  pin_out,
  output logic [WIDTH-1:0]  pin_oe,
  output logic [WIDTH-1:0]  pin_pullup,
  output logic [WIDTH-1:0]  pin_slew,
  input  logic [WIDTH-1:0]  per_own,
  input  logic [WIDTH-1:0]  per_out,
  input  logic [WIDTH-1:0]  per_oe
);
  logic [WIDTH-1:0] pin_sync, latch_q, dir_q, pull_q, slew_q;

  gpio_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst(rst), .async_in(pin_in), .sync_out(pin_sync)
  );

  gpio_regfile #(.WIDTH(WIDTH), .ADDR_W(ADDR_W)) regs_i (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .pin_sync(pin_sync), .latch_q(latch_q),
    .dir_q(dir_q), .pull_q(pull_q), .slew_q(slew_q), .bus_rdata(bus_rdata)
  );

  gpio_pin_mux #(.WIDTH(WIDTH)) mux_i (
    .clk(clk), .rst(rst), .latch_q(latch_q), .dir_q(dir_q), .pull_q(pull_q),
    .slew_q(slew_q), .per_own(per_own), .per_out(per_out), .per_oe(per_oe),
    .pin_out(pin_out), .pin_oe(pin_oe), .pin_pullup(pin_pullup), .pin_slew(pin_slew)
  );
endmodule

// File: tb/gpio_port_ctrl_tb_top.sv
module gpio_port_ctrl_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [2:0] bus_addr = '0;
  logic bus_wr = 1'b0;
  logic [7:0] bus_wdata = '0, bus_rdata;
  logic [7:0] pin_in = '0, pin_out, pin_oe, pin_pullup, pin_slew;
  logic [7:0] per_own = '0, per_out = '0, per_oe = '0;
  int errors = 0;
  int checks = 0;

  always #2 clk = ~clk;

  gpio_port_ctrl dut_i (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .pin_pullup(pin_pullup),
    .pin_slew(pin_slew), .per_own(per_own), .per_out(per_out), .per_oe(per_oe)
  );

  typedef struct packed {
    logic [7:0] dir, own, poe, pout, pull, slew, latch, pin;
  } vec_t;

  localparam int NVEC = 5;
  localparam vec_t VECS [NVEC] = '{
    '{dir:8'hAA, own:8'hCC, poe:8'hF0, pout:8'h5A, pull:8'hFF, slew:8'hFF, latch:8'h3C, pin:8'h96},
    '{dir:8'hAA, own:8'hCC, poe:8'hF0, pout:8'hA5, pull:8'h0F, slew:8'hF0, latch:8'hC3, pin:8'h69},
    '{dir:8'h55, own:8'h33, poe:8'h0F, pout:8'hFF, pull:8'hF0, slew:8'h0F, latch:8'hFF, pin:8'h00},
    '{dir:8'h00, own:8'h00, poe:8'hFF, pout:8'h00, pull:8'hFF, slew:8'hFF, latch:8'h81, pin:8'hFF},
    '{dir:8'hFF, own:8'h00, poe:8'h00, pout:8'hFF, pull:8'hFF, slew:8'h66, latch:8'h18, pin:8'h00}
  };

  task automatic chk(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog expired");
    $display("  Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    chk("R1", "oe in reset", pin_oe, 8'h00);
    chk("R1", "pullup in reset", pin_pullup, 8'h00);
    rst = 1'b0;
    @(negedge clk);
    chk("R1", "oe after reset", pin_oe, 8'h00);
    chk("R1", "out after reset", pin_out, 8'h00);
    chk("R1", "slew after reset", pin_slew, 8'h00);
    for (int a = 1; a < 4; a++) begin
      rd(3'(a), v);
      chk("R1", "register after reset", v, 8'h00);
    end
    pin_in = 8'h00;
    repeat (3) @(negedge clk);
    rd(3'd0, v);
    chk("R1", "latch read after reset", v, 8'h00);

    for (int i = 0; i < NVEC; i++) begin
      vec_t t;
      logic [7:0] eoe, eout;
      t = VECS[i];
      @(negedge clk);
      per_own = t.own; per_oe = t.poe; per_out = t.pout; pin_in = t.pin;
      wr(3'd0, t.latch);
      wr(3'd1, t.pull);
      wr(3'd2, t.slew);
      wr(3'd3, t.dir);
      repeat (4) @(negedge clk);
      eoe  = (t.own & t.poe)  | (~t.own & t.dir);
      eout = (t.own & t.pout) | (~t.own & t.latch);
      chk("R8", "pin_oe", pin_oe, eoe);
      chk("R2", "pin_out", pin_out, eout);
      chk("R6", "pullup on non-owned", pin_pullup & ~t.own, t.pull & ~t.dir & ~t.own);
      chk("R9", "pullup on owned", pin_pullup & t.own, t.pull & ~t.dir & ~t.poe & t.own);
      chk("R7", "pin_slew", pin_slew, t.slew & eoe);
      rd(3'd0, v);
      chk("R3", "latch/pin read", v, (t.dir & t.latch) | (~t.dir & t.pin));
      rd(3'd1, v); chk("R4", "pullup readback", v, t.pull);
      rd(3'd2, v); chk("R4", "slew readback", v, t.slew);
      rd(3'd3, v); chk("R4", "dir readback", v, t.dir);
    end

    // R5: unmapped offsets (last table row leaves dir=FF pull=FF slew=66 latch=18)
    wr(3'd5, 8'h00);
    wr(3'd7, 8'h00);
    rd(3'd5, v); chk("R5", "unmapped read", v, 8'h00);
    rd(3'd3, v); chk("R5", "dir after unmapped write", v, 8'hFF);
    rd(3'd2, v); chk("R5", "slew after unmapped write", v, 8'h66);
    rd(3'd0, v); chk("R5", "latch after unmapped write", v, 8'h18);

    // R2: latch written while all pins are inputs, then exposed by turning drive on
    per_own = 8'h00;
    wr(3'd3, 8'h00);
    wr(3'd0, 8'hE7);
    @(negedge clk);
    chk("R2", "latch not driven on inputs", pin_oe, 8'h00);
    chk("R2", "latch visible on pin_out", pin_out, 8'hE7);

    // R11: drive change one edge after the storing edge
    @(negedge clk);
    bus_addr = 3'd3; bus_wdata = 8'hFF; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
    chk("R11", "oe one edge after write", pin_oe, 8'h00);
    @(negedge clk);
    chk("R11", "oe two edges after write", pin_oe, 8'hFF);

    // R10: synchronizer delay with all pins as inputs and offset 0 held
    wr(3'd3, 8'h00);
    pin_in = 8'h00;
    bus_addr = 3'd0;
    repeat (4) @(negedge clk);
    chk("R10", "settled low", bus_rdata, 8'h00);
    pin_in = 8'hB4;
    repeat (2) @(negedge clk);
    chk("R10", "still old after two edges", bus_rdata, 8'h00);
    @(negedge clk);
    chk("R10", "new after three edges", bus_rdata, 8'hB4);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule